// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial-interface front end of a small serial flash. It oversamples the chip select, serial clock and hold pins with the system clock. From the serial data input it assembles a one-byte opcode and then the address, dummy and data bytes that opcode calls for. It drives read data, the status byte or the signature byte back on the serial output. Neighbouring blocks supply array read data through a combinational read port, the status byte, and a busy flag for a running program, erase or status-write cycle. This block hands write-type commands on to them as a one-cycle command pulse.

Write-type commands are passed on only when chip select rises exactly on a byte boundary. Program and status-write data bytes are streamed out as they arrive, and the neighbour commits them only if the command pulse follows. The block also holds the deep power-down state and applies the hold pin. Hold is qualified by the serial clock being low.

Top module: `sflash_cmd_front`

## Requirements
- R1: After reset the output enable, `cmd_go`, `wr_vld` and `deep_pd` are 0. Input bits are taken MSB first, and the first byte of a selection is the opcode.
- R2: These opcodes raise `cmd_go` for one cycle, with `cmd_op` equal to the opcode and `cmd_addr` equal to the three bytes after the opcode (first byte most significant), when chip select rises after exactly the stated number of whole bytes: 06h, 04h, C7h and B9h after 1 byte; 01h after 2; D8h after 4. For 02h the count must be 5 or more.
- R3: A write-type selection whose clock count is not a multiple of 8, or whose byte count does not meet R2, gives no `cmd_go`. Any other opcode never gives `cmd_go`.
- R4: Opcode 03h followed by a 3-byte address returns array bytes from `rd_addr`, starting at that address and incrementing after each byte.
- R5: Opcode 0Bh works as in R4, but one dummy byte follows the address.
- R6: Opcode 05h returns `status_in` for every byte clocked after the opcode.
- R7: Each data byte after the address of 02h, and the byte after opcode 01h, is presented on `wr_byte` with a one-cycle `wr_vld`.
- R8: An accepted B9h sets `deep_pd`. While it is set, every opcode except ABh is ignored: there is no `cmd_go` and no output.
- R9: Opcode ABh followed by 3 dummy bytes returns the signature 05h, repeated while clocking continues. Chip select rising after an ABh opcode clears `deep_pd`.
- R10: While `busy` is 1, every opcode except 05h is ignored, including 03h, B9h and ABh.
- R11: Hold takes effect, and ends, only while SCK is low. While hold is active the output is disabled and SCK and SI edges are ignored. Chip select rising during hold discards the partial command.
- R12: With chip select high the output is disabled. After reset, a falling edge of chip select is needed before any command is taken.
- R13: Input is sampled on rising SCK and output changes after falling SCK, in both SPI mode 0 and SPI mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_csn | input | 1 | Chip select, active low |
| spi_hold_n | input | 1 | Hold, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| busy | input | 1 | A program, erase or status-write cycle is running |
| status_in | input | 8 | Status byte to return |
| rd_addr | output | 24 | Array read address |
| rd_data | input | 8 | Array byte at rd_addr (combinational) |
| cmd_go | output | 1 | One-cycle pulse: accepted write-type command |
| cmd_op | output | 8 | Opcode of the accepted command |
| cmd_addr | output | 24 | Address bytes of the accepted command |
| wr_vld | output | 1 | One-cycle pulse: data byte received |
| wr_byte | output | 8 | Received data byte |
| deep_pd | output | 1 | Deep power-down state |

## Verification
The bench walks a table of write-type selections that alternate between mode 0 and mode 3, with short byte counts and stray trailing bits. A design that only checked the opcode, or counted bytes without checking bit alignment, would pulse `cmd_go` on rejected entries. Directed cases enter hold in the middle of an opcode and in the middle of a read. A design whose hold did not gate the clock would assemble a wrong opcode or return shifted data, and a design whose hold did not reset on chip select would keep a partial opcode. Further cases issue commands while busy and in deep power-down, and take chip select low through reset. A faulty design would answer reads, accept commands, or execute a command with no falling edge of chip select.

// File: rtl/sflash_cmd_front.sv
`timescale 1ns/1ps
module sflash_cmd_front #(
  parameter logic [7:0] SIG_ID = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_csn,
  input  logic        spi_hold_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  input  logic        busy,
  input  logic [7:0]  status_in,
  output logic [23:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        cmd_go,
  output logic [7:0]  cmd_op,
  output logic [23:0] cmd_addr,
  output logic        wr_vld,
  output logic [7:0]  wr_byte,
  output logic        deep_pd
);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05,
                         OP_WRSR = 8'h01, OP_READ = 8'h03, OP_FAST = 8'h0B,
                         OP_PP   = 8'h02, OP_SE   = 8'hD8, OP_BE   = 8'hC7,
                         OP_DP   = 8'hB9, OP_RES  = 8'hAB;

  logic [2:0]  sck_q, cs_q;
  logic [1:0]  hold_q;
  logic        active, hold_act, ign, out_on;
  logic [2:0]  bitcnt, bytecnt;
  logic [7:0]  shift, op, out_sh;
  logic [23:0] addr;

  logic sck_s, csn_s, sck_r, sck_f, cs_f, cs_r, rise, fall;
  assign sck_s = sck_q[1];
  assign csn_s = cs_q[1];
  assign sck_r = sck_q[1] & ~sck_q[2];
  assign sck_f = ~sck_q[1] & sck_q[2];
  assign cs_f  = ~cs_q[1] & cs_q[2];
  assign cs_r  = cs_q[1] & ~cs_q[2];
  assign rise  = sck_r & active & ~hold_act & ~csn_s;
  assign fall  = sck_f & active & ~hold_act & ~csn_s;

  logic [7:0] sh_nx;
  logic       byte_done;
  assign sh_nx     = {shift[6:0], spi_mosi};
  assign byte_done = rise & (bitcnt == 3'd7);

  assign spi_miso    = out_sh[7];
  assign spi_miso_oe = out_on & active & ~hold_act & ~csn_s;

  logic exec_ok;
  always_comb begin
    case (op)
      OP_WREN, OP_WRDI, OP_BE, OP_DP: exec_ok = (bytecnt == 3'd1);
      OP_WRSR:                        exec_ok = (bytecnt == 3'd2);
      OP_SE:                          exec_ok = (bytecnt == 3'd4);
      OP_PP:                          exec_ok = (bytecnt >= 3'd5);
      default:                        exec_ok = 1'b0;
    endcase
  end

  logic out_want, from_array;
  assign from_array = (op == OP_READ) || (op == OP_FAST);
  always_comb begin
    case (op)
      OP_RDSR: out_want = (bytecnt >= 3'd1);
      OP_READ: out_want = (bytecnt >= 3'd4);
      OP_FAST: out_want = (bytecnt >= 3'd5);
      OP_RES:  out_want = (bytecnt >= 3'd4);
      default: out_want = 1'b0;
    endcase
    if (ign || bytecnt == 3'd0) out_want = 1'b0;
  end

  logic [7:0] out_src;
  assign out_src = (op == OP_RDSR) ? status_in :
                   (op == OP_RES)  ? SIG_ID    : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '0;
      hold_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[1:0], spi_csn};
      hold_q <= {hold_q[0], spi_hold_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_act <= 1'b0;
    else if (csn_s || !active) hold_act <= 1'b0;
    else if (!sck_s)           hold_act <= ~hold_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; ign <= 1'b0; out_on <= 1'b0;
      bitcnt <= '0; bytecnt <= '0;
      shift <= '0; op <= '0; out_sh <= '0; addr <= '0;
      rd_addr <= '0; cmd_go <= 1'b0; cmd_op <= '0; cmd_addr <= '0;
      wr_vld <= 1'b0; wr_byte <= '0; deep_pd <= 1'b0;
    end else begin
      cmd_go <= 1'b0;
      wr_vld <= 1'b0;
      if (cs_f) begin
        active <= 1'b1; ign <= 1'b0; out_on <= 1'b0;
        bitcnt <= '0; bytecnt <= '0;
      end else if (cs_r) begin
        active <= 1'b0;
        out_on <= 1'b0;
        if (active && !ign && !busy && bitcnt == 3'd0 && exec_ok) begin
          cmd_go   <= 1'b1;
          cmd_op   <= op;
          cmd_addr <= addr;
        end
        if (active && !ign && op == OP_RES && bytecnt != 3'd0)
          deep_pd <= 1'b0;
      end else begin
        if (rise) begin
          shift  <= sh_nx;
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          if (bytecnt != 3'd7) bytecnt <= bytecnt + 3'd1;
          if (bytecnt == 3'd0) begin
            op  <= sh_nx;
            ign <= (busy && sh_nx != OP_RDSR) || (deep_pd && sh_nx != OP_RES);
          end
          if (bytecnt >= 3'd1 && bytecnt <= 3'd3)
            addr <= {addr[15:0], sh_nx};
          if (bytecnt == 3'd3)
            rd_addr <= {addr[15:0], sh_nx};
          if (!ign && ((op == OP_PP && bytecnt >= 3'd4) ||
                       (op == OP_WRSR && bytecnt == 3'd1))) begin
            wr_vld  <= 1'b1;
            wr_byte <= sh_nx;
          end
        end
        if (fall && bitcnt == 3'd0 && out_want) begin
          out_sh <= out_src;
          out_on <= 1'b1;
          if (from_array) rd_addr <= rd_addr + 24'd1;
        end else if (fall && out_on) begin
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
      if (cmd_go && cmd_op == OP_DP) deep_pd <= 1'b1;
    end
  end
endmodule

// File: rtl/sflash_cmd_front_chk.sv
`timescale 1ns/1ps
module sflash_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_csn,
  input logic       spi_miso_oe,
  input logic       busy,
  input logic       cmd_go,
  input logic [7:0] cmd_op,
  input logic       deep_pd
);
  assert_go_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !$past(busy));

  assert_go_not_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !$past(deep_pd));

  assert_pd_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_pd) |-> ($past(cmd_go) && $past(cmd_op) == 8'hB9));

  assert_go_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (cmd_op inside {8'h06, 8'h04, 8'h01, 8'h02, 8'hD8, 8'hC7, 8'hB9}));

  assert_cs_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2)) |-> !spi_miso_oe);
endmodule

bind sflash_cmd_front sflash_cmd_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso_oe(spi_miso_oe),
  .busy(busy), .cmd_go(cmd_go), .cmd_op(cmd_op), .deep_pd(deep_pd)
);

// File: tb/sflash_cmd_front_tb_top.sv
`timescale 1ns/1ps
module sflash_cmd_front_tb_top;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, hold_n = 1'b1, mosi = 1'b0;
  logic busy = 1'b0;
  logic [7:0] status_in = 8'h83;
  logic miso, miso_oe, cmd_go, wr_vld, deep_pd;
  logic [23:0] rd_addr, cmd_addr;
  logic [7:0] rd_data, cmd_op, wr_byte;
  logic cpol = 1'b0;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int go_cnt = 0, wr_cnt = 0, oe_cnt = 0;
  logic [7:0] last_op = '0, last_wr = '0;
  logic [23:0] last_addr = '0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arr(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign rd_data = arr(rd_addr);

  sflash_cmd_front dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_hold_n(hold_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .busy(busy),
    .status_in(status_in), .rd_addr(rd_addr), .rd_data(rd_data), .cmd_go(cmd_go),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wr_vld(wr_vld), .wr_byte(wr_byte),
    .deep_pd(deep_pd)
  );

  always @(posedge clk) begin
    if (cmd_go) begin go_cnt <= go_cnt + 1; last_op <= cmd_op; last_addr <= cmd_addr; end
    if (wr_vld) begin wr_cnt <= wr_cnt + 1; last_wr <= wr_byte; end
    if (miso_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cs_on();
    sck = cpol; tick(16); csn = 1'b0; tick(16);
  endtask

  task automatic cs_off();
    tick(HP); csn = 1'b1; tick(16); sck = cpol; tick(4);
  endtask

  task automatic xbit(input logic b, output logic r);
    if (cpol) sck = 1'b0;
    mosi = b; tick(HP);
    r = miso; sck = 1'b1; tick(HP);
    if (!cpol) sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(t[i], r[i]);
  endtask

  localparam logic [15:0] VEC [0:10] = '{
    {8'h06, 3'd0, 3'd0, 1'b1, 1'b0},
    {8'h04, 3'd0, 3'd0, 1'b1, 1'b0},
    {8'h06, 3'd0, 3'd3, 1'b0, 1'b0},
    {8'hC7, 3'd0, 3'd0, 1'b1, 1'b0},
    {8'hD8, 3'd3, 3'd0, 1'b1, 1'b0},
    {8'hD8, 3'd2, 3'd0, 1'b0, 1'b0},
    {8'h01, 3'd1, 3'd0, 1'b1, 1'b0},
    {8'h01, 3'd1, 3'd5, 1'b0, 1'b0},
    {8'h02, 3'd4, 3'd0, 1'b1, 1'b0},
    {8'h02, 3'd4, 3'd1, 1'b0, 1'b0},
    {8'h02, 3'd3, 3'd0, 1'b0, 1'b0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    tick(150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic b;
    int g0, w0, o0;
    tick(5);
    rst_n = 1'b1;
    tick(8);
    chk("R1 oe after reset", miso_oe, 0);
    chk("R1 deep_pd after reset", deep_pd, 0);
    chk("R1 no go after reset", go_cnt, 0);

    for (int i = 0; i < 11; i++) begin
      logic [15:0] v;
      v = VEC[i];
      cpol = i[0];
      g0 = go_cnt;
      cs_on();
      xbyte(v[15:8], r);
      for (int j = 0; j < int'(v[7:5]); j++) xbyte(8'h10 + 8'(j), r);
      for (int j = 0; j < int'(v[4:2]); j++) xbit(1'b1, b);
      cs_off();
      if (v[1]) begin
        chk("R2 accepted", go_cnt - g0, 1);
        chk("R2 opcode", last_op, v[15:8]);
        if (v[15:8] == 8'hD8) chk("R2 address", last_addr, 24'h101112);
      end else begin
        chk("R3 rejected", go_cnt - g0, 0);
      end
    end

    cpol = 1'b0;
    cs_on();
    xbyte(8'h03, r); xbyte(8'h01, r); xbyte(8'h23, r); xbyte(8'h40, r);
    xbyte(8'h00, r); chk("R4 R13 read mode0 byte0", r, arr(24'h012340));
    xbyte(8'h00, r); chk("R4 read byte1", r, arr(24'h012341));
    xbyte(8'h00, r); chk("R4 read byte2", r, arr(24'h012342));
    cs_off();

    cpol = 1'b1;
    cs_on();
    xbyte(8'h0B, r); xbyte(8'h00, r); xbyte(8'hFF, r); xbyte(8'hFE, r); xbyte(8'hA5, r);
    xbyte(8'h00, r); chk("R5 R13 fast read mode3 byte0", r, arr(24'h00FFFE));
    xbyte(8'h00, r); chk("R5 fast read byte1", r, arr(24'h00FFFF));
    cs_off();

    cpol = 1'b0;
    cs_on();
    xbyte(8'h05, r);
    xbyte(8'h00, r); chk("R6 status byte0", r, 8'h83);
    xbyte(8'h00, r); chk("R6 status byte1", r, 8'h83);
    cs_off();

    g0 = go_cnt; w0 = wr_cnt;
    cs_on();
    xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h10, r);
    xbyte(8'h3C, r); xbyte(8'h7E, r);
    cs_off();
    chk("R7 data byte count", wr_cnt - w0, 2);
    chk("R7 last data byte", last_wr, 8'h7E);
    chk("R7 program accepted", go_cnt - g0, 1);
    chk("R7 program address", last_addr, 24'h000010);

    busy = 1'b1;
    g0 = go_cnt;
    cs_on(); xbyte(8'h06, r); cs_off();
    chk("R10 command while busy", go_cnt - g0, 0);
    o0 = oe_cnt;
    cs_on();
    xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r);
    cs_off();
    chk("R10 read while busy silent", oe_cnt - o0, 0);
    cs_on(); xbyte(8'h05, r); xbyte(8'h00, r); cs_off();
    chk("R10 status while busy", r, 8'h83);
    busy = 1'b0;

    cs_on(); xbyte(8'hB9, r); cs_off();
    chk("R8 deep power-down entered", deep_pd, 1);
    g0 = go_cnt;
    cs_on(); xbyte(8'h06, r); cs_off();
    chk("R8 command ignored in power-down", go_cnt - g0, 0);
    o0 = oe_cnt;
    cs_on();
    xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r);
    cs_off();
    chk("R8 read ignored in power-down", oe_cnt - o0, 0);
    chk("R8 still in power-down", deep_pd, 1);
    cs_on();
    xbyte(8'hAB, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r);
    xbyte(8'h00, r); chk("R9 signature byte0", r, 8'h05);
    xbyte(8'h00, r); chk("R9 signature byte1", r, 8'h05);
    cs_off();
    chk("R9 power-down released", deep_pd, 0);

    g0 = go_cnt;
    cs_on();
    for (int i = 0; i < 4; i++) xbit(1'b0, b);
    hold_n = 1'b0; tick(16);
    mosi = 1'b1;
    for (int i = 0; i < 4; i++) begin sck = 1'b1; tick(HP); sck = 1'b0; tick(HP); end
    hold_n = 1'b1; tick(16);
    xbit(1'b0, b); xbit(1'b1, b); xbit(1'b1, b); xbit(1'b0, b);
    cs_off();
    chk("R11 opcode across hold", go_cnt - g0, 1);
    chk("R11 opcode value", last_op, 8'h06);

    cs_on();
    xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h01, r); xbyte(8'h00, r);
    xbyte(8'h00, r); chk("R4 read before hold", r, arr(24'h000100));
    hold_n = 1'b0; tick(16);
    chk("R11 output off in hold", miso_oe, 0);
    for (int i = 0; i < 8; i++) begin sck = 1'b1; tick(HP); sck = 1'b0; tick(HP); end
    hold_n = 1'b1; tick(16);
    chk("R11 output back after hold", miso_oe, 1);
    xbyte(8'h00, r); chk("R11 read after hold", r, arr(24'h000101));
    cs_off();

    g0 = go_cnt;
    cs_on();
    for (int i = 0; i < 4; i++) xbit(1'b0, b);
    hold_n = 1'b0; tick(16);
    csn = 1'b1; tick(16);
    hold_n = 1'b1; tick(16);
    cs_on(); xbyte(8'h04, r); cs_off();
    chk("R11 one command after hold reset", go_cnt - g0, 1);
    chk("R11 fresh opcode", last_op, 8'h04);
    chk("R12 output off when deselected", miso_oe, 0);

    rst_n = 1'b0; csn = 1'b0; sck = 1'b0; tick(4);
    rst_n = 1'b1; tick(16);
    g0 = go_cnt;
    xbyte(8'h06, r);
    cs_off();
    chk("R12 no command without select edge", go_cnt - g0, 0);
    cs_on(); xbyte(8'h06, r); cs_off();
    chk("R12 command after select edge", go_cnt - g0, 1);

    finish_run();
  end
endmodule